// File: doc/BRIEF.md
# Early-Terminating Sequential Integer Multiplier

This block multiplies two 32-bit integers and returns the full 64-bit product. It is built for a processor's integer unit, where most operands are small. The multiplier operand is examined when a request arrives and sorted into a width class. The datapath then retires one 8-bit digit of that operand per cycle. It stops once the remaining digits carry no information, so small operands finish in fewer cycles.

A request is a single-cycle `start_i` pulse carrying both operands and a signedness flag. In the cycle after the request is accepted, `busy_o` rises. `done_o` marks the one cycle in which the product becomes valid. The product stays on `prod_o` until the next request is accepted. Signed operation gives a two's-complement product. Unsigned operation treats both operands as non-negative.

Latency counts clock cycles. A `start_i` sampled at the end of cycle c produces `done_o` high during cycle c+N, where N is set by the multiplier operand `b_i`:

- N = 1 when `b_i` is zero.
- N = 2 for the 8-bit class.
- N = 3 for the 16-bit class.
- N = 5 otherwise.

Top module: `early_mul`

## Requirements
- R1: While reset is held, and after it is released with no request, `busy_o` and `done_o` are 0 and `prod_o` is 0.
- R2: With `signed_i`=0, the product equals the unsigned 32×32 product of `a_i` and `b_i`, zero-extended to 64 bits.
- R3: With `signed_i`=1, the product equals the two's-complement 64-bit product of `a_i` and `b_i`, each read as a signed 32-bit value.
- R4: When `b_i` is 0, `done_o` is high in cycle c+1 with `prod_o`=0, and `busy_o` never rises.
- R5: The 8-bit class gives N=2 with `busy_o` high for one cycle. Unsigned, this class is `b_i`<256. Signed, it is bits 31..7 of `b_i` all equal.
- R6: The 16-bit class gives N=3 with `busy_o` high for two cycles. Unsigned, this class is bits 31..16 all zero. Signed, it is bits 31..15 all equal. It applies only when the 8-bit class does not.
- R7: Every other nonzero `b_i` gives N=5, with `busy_o` high for four cycles.
- R8: `done_o` is high for exactly one cycle per request, and `prod_o` holds its value until the next accepted request.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running request completes with its own operands and latency, and no extra `done_o` follows.
- R10: `busy_o` is high from cycle c+1 through cycle c+N-1, and `done_o` and `busy_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request strobe |
| signed_i | input | 1 | 1 selects two's-complement operands |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier operand; sets the latency class |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Product valid this cycle |
| prod_o | output | 64 | 64-bit product |

## Verification
A wrong iteration count or a misclassified operand shows up at the ports at once. `done_o` moves off its expected cycle by one or more, and `busy_o` stays high too long or too briefly. A broken digit weighting or a wrong top-digit sign fix shows as a wrong `prod_o` in the `done_o` cycle. This needs operands whose upper digits are nonzero or negative. A stale accumulator or a request accepted while busy shows as a changed `prod_o` or as an extra `done_o` within a few cycles after the first completion.

// File: rtl/emul_pkg.sv
package emul_pkg;
  localparam int unsigned OP_W  = 32;
  localparam int unsigned DIG_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/emul_class.sv
module emul_class #(
  parameter int unsigned W  = emul_pkg::OP_W,
  parameter int unsigned D  = emul_pkg::DIG_W,
  parameter int unsigned CW = 3
) (
  input  logic [W-1:0]  b,
  input  logic          sgn,
  output logic [CW-1:0] niter
);
  localparam int unsigned NDIG = W / D;

  logic is_zero, fits1, fits2;

  always_comb begin
    is_zero = (b == '0);
    if (sgn) begin
      fits1 = (&b[W-1:D-1]) | ~(|b[W-1:D-1]);
      fits2 = (&b[W-1:2*D-1]) | ~(|b[W-1:2*D-1]);
    end else begin
      fits1 = ~(|b[W-1:D]);
      fits2 = ~(|b[W-1:2*D]);
    end
    if (is_zero)    niter = '0;
    else if (fits1) niter = CW'(1);
    else if (fits2) niter = CW'(2);
    else            niter = CW'(NDIG);
  end
endmodule

// File: rtl/emul_pp.sv
module emul_pp #(
  parameter int unsigned PW = 2 * emul_pkg::OP_W,
  parameter int unsigned D  = emul_pkg::DIG_W
) (
  input  logic [PW-1:0] mcand,
  input  logic [D-1:0]  digit,
  input  logic          neg_top,
  output logic [PW-1:0] pp
);
  logic [PW-1:0] zext_prod;

  always_comb begin
    zext_prod = mcand * PW'(digit);
    // a negative top digit weighs 2^D less than its unsigned reading
    if (neg_top && digit[D-1]) pp = zext_prod - (mcand << D);
    else                       pp = zext_prod;
  end
endmodule

// File: rtl/emul_core.sv
module emul_core
  import emul_pkg::*;
#(
  parameter int unsigned W  = OP_W,
  parameter int unsigned D  = DIG_W,
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sgn,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [CW-1:0] niter,
  input  logic [2*W-1:0] pp,
  output logic [2*W-1:0] mcand,
  output logic [D-1:0]  digit,
  output logic          neg_top,
  output logic          busy,
  output logic          done,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;

  run_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] mcand_q, mcand_d;
  logic [W-1:0]  mplier_q, mplier_d;
  logic [PW-1:0] acc_q, acc_d;
  logic          sgn_q, sgn_d;
  logic          done_q, done_d;
  logic          accept, upd_en;

  assign accept  = start && (state_q == ST_IDLE);
  assign upd_en  = accept || (state_q == ST_RUN);
  assign mcand   = mcand_q;
  assign digit   = mplier_q[D-1:0];
  assign neg_top = sgn_q && (cnt_q == CW'(1));
  assign busy    = (state_q == ST_RUN);
  assign done    = done_q;
  assign prod    = acc_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    acc_d    = acc_q;
    sgn_d    = sgn_q;
    done_d   = 1'b0;
    if (accept) begin
      sgn_d    = sgn;
      mcand_d  = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
      mplier_d = b;
      acc_d    = '0;
      cnt_d    = niter;
      if (niter == '0) done_d  = 1'b1;
      else             state_d = ST_RUN;
    end else if (state_q == ST_RUN) begin
      acc_d    = acc_q + pp;
      mcand_d  = mcand_q << D;
      mplier_d = mplier_q >> D;
      cnt_d    = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      sgn_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      if (upd_en) begin
        state_q  <= state_d;
        cnt_q    <= cnt_d;
        mcand_q  <= mcand_d;
        mplier_q <= mplier_d;
        acc_q    <= acc_d;
        sgn_q    <= sgn_d;
      end
    end
  end

  // R9
  ign_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start) |=> (mplier_q == ($past(mplier_q) >> D)));

  // R10
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=>
      ((state_q == ST_RUN && cnt_q == $past(cnt_q) - CW'(1)) ||
       (state_q == ST_IDLE && done_q)));

  // R4
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && niter == '0) |=> (done_q && acc_q == '0 && state_q == ST_IDLE));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start) |=> !done_q);
endmodule

// File: rtl/early_mul.sv
module early_mul
  import emul_pkg::*;
#(
  parameter int unsigned W = OP_W,
  parameter int unsigned D = DIG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           signed_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*W-1:0] prod_o
);
  localparam int unsigned NDIG = W / D;
  localparam int unsigned CW   = $clog2(NDIG + 1);
  localparam int unsigned PW   = 2 * W;

  logic [1:0]    rst_sync_q;
  logic          rst_sync_n;
  logic [CW-1:0] niter;
  logic [PW-1:0] mcand, pp;
  logic [D-1:0]  digit;
  logic          neg_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  emul_class #(.W(W), .D(D), .CW(CW)) i_class (
    .b(b_i), .sgn(signed_i), .niter(niter)
  );

  emul_pp #(.PW(PW), .D(D)) i_pp (
    .mcand(mcand), .digit(digit), .neg_top(neg_top), .pp(pp)
  );

  emul_core #(.W(W), .D(D), .CW(CW)) i_core (
    .clk(clk), .rst_n(rst_sync_n), .start(start_i), .sgn(signed_i),
    .a(a_i), .b(b_i), .niter(niter), .pp(pp), .mcand(mcand),
    .digit(digit), .neg_top(neg_top), .busy(busy_o), .done(done_o),
    .prod(prod_o)
  );

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !busy_o);

  // R8
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

// File: tb/test_early_mul.sv
module test_early_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        busy_o, done_o;
  logic [63:0] prod_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  early_mul i_early_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below 50000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [31:0] b, input bit sg);
    int sb;
    sb = $signed(b);
    if (b == 0) return 1;
    if (sg) begin
      if (sb >= -128 && sb <= 127) return 2;
      if (sb >= -32768 && sb <= 32767) return 3;
    end else begin
      if (b < 32'd256) return 2;
      if (b < 32'd65536) return 3;
    end
    return 5;
  endfunction

  function automatic logic [63:0] exp_prod(input logic [31:0] a, input logic [31:0] b, input bit sg);
    logic [63:0] ea, eb;
    ea = sg ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sg ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  // issue one request at a negedge, check latency, busy, product and hold
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit sg,
                        input string req, input bit poke_busy);
    int lat, n;
    logic [63:0] ep;
    n  = exp_lat(b, sg);
    ep = exp_prod(a, b, sg);
    a_i = a; b_i = b; signed_i = sg; start_i = 1'b1;
    lat = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke_busy && k == 2) begin
        a_i = 32'h1234_5678; b_i = 32'd0; signed_i = 1'b0; start_i = 1'b1;
      end
      if (done_o) begin lat = k; break; end
      chk(busy_o == 1'b1, {req, " busy before done"}, 64'(busy_o), 64'd1);
    end
    start_i = 1'b0;
    chk(lat == n, {req, " latency"}, 64'(lat), 64'(n));
    chk(prod_o == ep, {req, " product"}, prod_o, ep);
    chk(busy_o == 1'b0, {req, " R10 no busy with done"}, 64'(busy_o), 64'd0);
    @(negedge clk);
    chk(done_o == 1'b0, {req, " R8 done one cycle"}, 64'(done_o), 64'd0);
    chk(prod_o == ep, {req, " R8 product held"}, prod_o, ep);
  endtask

  task automatic t_reset;
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", {62'b0, busy_o, done_o}, 64'd0);
    chk(prod_o == 64'd0, "R1 product in reset", prod_o, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags after reset", {62'b0, busy_o, done_o}, 64'd0);
    chk(prod_o == 64'd0, "R1 product after reset", prod_o, 64'd0);
  endtask

  task automatic t_zero;
    run_op(32'hDEAD_BEEF, 32'd0, 1'b0, "R4 unsigned zero", 1'b0);
    run_op(32'h8000_0000, 32'd0, 1'b1, "R4 signed zero", 1'b0);
  endtask

  task automatic t_byte;
    run_op(32'hFFFF_FFFF, 32'd255, 1'b0, "R5 R2 byte unsigned max", 1'b0);
    run_op(32'd12345, 32'd1, 1'b0, "R5 R2 byte one", 1'b0);
    run_op(32'h7FFF_FFFF, 32'hFFFF_FF80, 1'b1, "R5 R3 byte signed -128", 1'b0);
    run_op(32'hFFFF_FFF9, 32'd127, 1'b1, "R5 R3 byte signed 127", 1'b0);
    run_op(32'd3, 32'hFFFF_FFFF, 1'b1, "R5 R3 byte signed -1", 1'b0);
  endtask

  task automatic t_half;
    run_op(32'hCAFE_F00D, 32'd256, 1'b0, "R6 R2 half low edge", 1'b0);
    run_op(32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, "R6 R2 half max", 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_8000, 1'b1, "R6 R3 half signed min", 1'b0);
    run_op(32'd1000, 32'd128, 1'b1, "R6 R3 signed 128", 1'b0);
  endtask

  task automatic t_full;
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 R2 full max", 1'b0);
    run_op(32'h1234_5678, 32'h0001_0000, 1'b0, "R7 R2 full low edge", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R7 R3 full signed min", 1'b0);
    run_op(32'hFFFF_1234, 32'h0000_8000, 1'b1, "R7 R3 signed 32768", 1'b0);
    run_op(32'h7654_3210, 32'h8765_4321, 1'b1, "R7 R3 full mixed", 1'b0);
  endtask

  task automatic t_ignore;
    run_op(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1'b0, "R9 start while busy", 1'b1);
    for (int k = 0; k < 3; k++) begin
      chk(done_o == 1'b0, "R9 no extra done", 64'(done_o), 64'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_back2back;
    run_op(32'd7, 32'd9, 1'b0, "R8 first of pair", 1'b0);
    run_op(32'd11, 32'hFFFF_FFF0, 1'b1, "R8 second of pair", 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_byte();
    t_half();
    t_full();
    t_ignore();
    t_back2back();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule